// File: doc/BRIEF.md
# Receive Message Queue with Overflow Lock

This block is the receive-side holding queue of a CAN controller. The protocol engine hands it complete messages, each an identifier word plus a data word. Software reads the oldest message and then releases it. The queue holds three messages. It reports how many it holds, whether it is full, and whether a message arrived while it was full.

Two policies cover an arrival at a full queue, and a configuration bit picks one.

- **Lock clear:** the arrival overwrites the newest stored message, so the two oldest messages survive.
- **Lock set:** the arrival is thrown away, so the three stored messages stay as they are.

Either way a sticky overrun flag is raised. Software clears it by pulsing the clear input.

Both data ports use valid/ready, with the following back-pressure rules.

- **Push port:** it never applies back-pressure. `in_ready` is tied high, and an arrival at a full queue is handled by the lock policy rather than stalled.
- **Read port:** it presents the oldest message on `out_*` while `out_valid` is high. A cycle with `out_valid` and `out_ready` both high releases that message. A release request while the queue is empty is ignored.

Top module: `rxq_fifo3`

## Requirements
- R1: The queue holds at most 3 messages. `fill_level` reports 0 to 3, and `full` is high exactly when the level is 3.
- R2: Messages leave in arrival order. `out_id`/`out_data` show the oldest stored message, and a release removes it and lowers the level by one.
- R3: With `lock_mode` low, a push into a full queue with no release in that cycle replaces the newest (third) entry. The two oldest entries are kept. After pushes 1..5 with no release, the queue reads out 1, 2, 5.
- R4: With `lock_mode` high, a push into a full queue with no release in that cycle is discarded and the queue is unchanged. After pushes 1..5 with no release, the queue reads out 1, 2, 3.
- R5: A push into a full queue with no release in the same cycle sets `overrun`. The flag stays high until a cycle with `overrun_clr` high. If a set and a clear fall in the same cycle, the set wins.
- R6: A release request (`out_ready` high) while the queue is empty has no effect. The level stays 0 and `out_valid` stays low.
- R7: `out_valid` is high exactly when the level is nonzero.
- R8: A push and a release in the same cycle on a full queue remove the oldest message and append the new one. The level stays 3 and `overrun` is not set.
- R9: After reset the queue is empty and `overrun` is low.
- R10: `in_ready` is always high. Every push is taken in the cycle it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_mode | input | 1 | 1: drop arrivals at a full queue; 0: overwrite the newest entry |
| in_valid | input | 1 | Push request from the protocol engine |
| in_ready | output | 1 | Always 1 |
| in_id | input | ID_W (29) | Identifier of the arriving message |
| in_data | input | DATA_W (64) | Data of the arriving message |
| out_valid | output | 1 | A message is pending |
| out_ready | input | 1 | Release of the oldest message |
| out_id | output | ID_W (29) | Identifier of the oldest message |
| out_data | output | DATA_W (64) | Data of the oldest message |
| fill_level | output | 2 | Number of stored messages, 0 to 3 |
| full | output | 1 | Level equals 3 |
| overrun | output | 1 | Sticky flag: a message arrived while the queue was full |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
Two pairs of functions can fall in the same cycle.

- **Push with release:** on a full queue this must act as an ordinary append with no overrun. On an empty queue the release must be ignored while the push lands. The bench provokes both cases directly and then mixes them at random, checking the order and flag against a queue model.
- **Overrun set with overrun clear:** the bench raises the clear in the same cycle as a full-queue push and expects the flag to stay set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // What a push does in a given cycle
  typedef enum logic [1:0] {
    ACT_IDLE      = 2'd0,
    ACT_APPEND    = 2'd1,
    ACT_OVERWRITE = 2'd2,
    ACT_DROP      = 2'd3
  } push_act_e;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_mode,
  input  logic             push,
  input  logic             pop,
  input  logic             ovr_clr,
  output logic [LVL_W-1:0] level,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             shift,
  output logic             ovr
);

  push_act_e        act;
  logic             is_full;
  logic             is_empty;
  logic             pop_eff;
  logic             ovr_evt;
  logic [LVL_W-1:0] level_nxt;
  logic [LVL_W-1:0] append_pos;

  always_comb begin
    is_full  = (level == LVL_W'(DEPTH));
    is_empty = (level == '0);

    // A release on an empty queue is ignored
    pop_eff = pop && !is_empty;

    if (!push) begin
      act = ACT_IDLE;
    end else if (!is_full || pop_eff) begin
      act = ACT_APPEND;
    end else if (lock_mode) begin
      act = ACT_DROP;
    end else begin
      act = ACT_OVERWRITE;
    end

    // Slot positions are those after the shift has taken place
    append_pos = pop_eff ? (level - LVL_W'(1)) : level;
    shift      = pop_eff;
    wr_en      = (act == ACT_APPEND) || (act == ACT_OVERWRITE);
    wr_idx     = (act == ACT_OVERWRITE) ? IDX_W'(DEPTH - 1) : IDX_W'(append_pos);
    ovr_evt    = (act == ACT_OVERWRITE) || (act == ACT_DROP);
    level_nxt  = level + LVL_W'(act == ACT_APPEND) - LVL_W'(pop_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      level <= level_nxt;
    end
  end

  // Sticky overrun: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
    end else if (ovr_evt) begin
      ovr <= 1'b1;
    end else if (ovr_clr) begin
      ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_slots.sv
module rxq_slots #(
  parameter int DEPTH = 3,
  parameter int W     = 93,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head
);

  // Slot 0 is the oldest entry; a release shifts every slot down by one
  logic [W-1:0] slot_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic         hit;
    logic [W-1:0] q;

    assign hit       = wr_en && (wr_idx == IDX_W'(i));
    assign slot_v[i] = q;

    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wdata;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wdata;
        end else if (shift) begin
          q <= slot_v[i+1];
        end
      end
    end
  end

  assign head = slot_v[0];

endmodule

// File: rtl/rxq_fifo3.sv
module rxq_fifo3 #(
  parameter int DEPTH  = 3,
  parameter int ID_W   = 29,
  parameter int DATA_W = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int MSG_W = ID_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  fill_level,
  output logic              full,
  output logic              overrun,
  input  logic              overrun_clr
);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             shift;
  logic [MSG_W-1:0] head;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_mode(lock_mode),
    .push     (in_valid),
    .pop      (out_ready),
    .ovr_clr  (overrun_clr),
    .level    (fill_level),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .shift    (shift),
    .ovr      (overrun)
  );

  rxq_slots #(.DEPTH(DEPTH), .W(MSG_W)) u_slots (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wdata ({in_id, in_data}),
    .head  (head)
  );

  assign in_ready  = 1'b1;
  assign out_valid = (fill_level != '0);
  assign full      = (fill_level == LVL_W'(DEPTH));
  assign out_id    = head[MSG_W-1:DATA_W];
  assign out_data  = head[DATA_W-1:0];

endmodule

// File: rtl/rxq_fifo3_chk.sv
module rxq_fifo3_chk #(
  parameter int DEPTH = 3,
  parameter int ID_W  = 29,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_mode,
  input logic             in_valid,
  input logic             out_ready,
  input logic             out_valid,
  input logic [ID_W-1:0]  out_id,
  input logic [LVL_W-1:0] fill_level,
  input logic             full,
  input logic             overrun,
  input logic             overrun_clr
);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH));

  p_release_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> (fill_level == $past(fill_level) - LVL_W'(1)));

  p_head_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready) |=> (out_id == $past(out_id)));

  p_lock_stays_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode && full && in_valid && !out_ready) |=> full);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !out_ready) |=> overrun);

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  p_empty_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && out_ready && !in_valid) |=> (fill_level == '0 && !out_valid));

  p_swap_no_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && out_ready && !overrun) |=> (full && !overrun));

endmodule

bind rxq_fifo3 rxq_fifo3_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_mode  (lock_mode),
  .in_valid   (in_valid),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .out_id     (out_id),
  .fill_level (fill_level),
  .full       (full),
  .overrun    (overrun),
  .overrun_clr(overrun_clr)
);

// File: tb/rxq_fifo3_tb.sv
module rxq_fifo3_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W       = 29;
  localparam int DATA_W     = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lock_mode = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ID_W-1:0]   in_id = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ID_W-1:0]   out_id;
  logic [DATA_W-1:0] out_data;
  logic [1:0]        fill_level;
  logic              full;
  logic              overrun;
  logic              overrun_clr = 1'b0;

  int    n_checks = 0;
  int    n_err    = 0;
  int    seq      = 0;
  bit    mon_en   = 1'b0;
  bit    done     = 1'b0;
  item_t exp_q[$];
  bit    exp_ovr  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_fifo3 u_dut (
    .clk(clk), .rst_n(rst_n), .lock_mode(lock_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_data(out_data),
    .fill_level(fill_level), .full(full), .overrun(overrun), .overrun_clr(overrun_clr)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model of one clock edge
  task automatic model_step(input bit push, input bit pop, input bit clr, input item_t it);
    int  old_n = exp_q.size();
    bit  pe    = pop && (old_n > 0);
    bit  evt;
    if (pe) void'(exp_q.pop_front());
    evt = push && (old_n == 3) && !pe;
    if (push) begin
      if (exp_q.size() < 3) exp_q.push_back(it);
      else if (!lock_mode) exp_q[2] = it;
    end
    if (evt) exp_ovr = 1'b1;
    else if (clr) exp_ovr = 1'b0;
  endtask

  // Driver: one cycle of stimulus, then the model follows the edge
  task automatic cyc(input bit push, input bit pop, input bit clr);
    item_t it;
    @(negedge clk);
    if (push) seq++;
    it.id       = ID_W'(seq);
    it.data     = {DATA_W/2'(seq), ~(DATA_W/2)'(seq)};
    in_valid    = push;
    in_id       = it.id;
    in_data     = it.data;
    out_ready   = pop;
    overrun_clr = clr;
    @(posedge clk);
    #1;
    model_step(push, pop, clr, it);
    in_valid    = 1'b0;
    out_ready   = 1'b0;
    overrun_clr = 1'b0;
  endtask

  task automatic pop_expect(input int exp_id, input string req);
    @(negedge clk);
    #2;
    check(req, 128'(out_id), 128'(exp_id));
    cyc(0, 1, 0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) cyc(0, 1, 0);
  endtask

  // Monitor: compares the design against the scoreboard every cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en) begin
        check("R1 level", 128'(fill_level), 128'(exp_q.size()));
        check("R1 full", 128'(full), 128'(exp_q.size() == 3));
        check("R7 out_valid", 128'(out_valid), 128'(exp_q.size() != 0));
        check("R5 overrun", 128'(overrun), 128'(exp_ovr));
        if (exp_q.size() != 0) begin
          check("R2 head", 128'({out_id, out_data}), 128'(exp_q[0]));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state, R10 ready
    check("R9 level", 128'(fill_level), 128'(0));
    check("R9 valid", 128'(out_valid), 128'(0));
    check("R9 overrun", 128'(overrun), 128'(0));
    check("R10 in_ready", 128'(in_ready), 128'(1));
    mon_en = 1'b1;

    // R3: lock clear, five pushes then read out 1,2,5
    lock_mode = 1'b0;
    seq = 0;
    for (int k = 0; k < 5; k++) cyc(1, 0, 0);
    #1;
    check("R5 overrun after lock-off overflow", 128'(overrun), 128'(1));
    check("R10 in_ready while full", 128'(in_ready), 128'(1));
    pop_expect(1, "R3 first");
    pop_expect(2, "R3 second");
    pop_expect(5, "R3 newest kept");
    cyc(0, 0, 1);
    #1;
    check("R5 cleared", 128'(overrun), 128'(0));

    // R4: lock set, read out 1,2,3
    lock_mode = 1'b1;
    seq = 0;
    for (int k = 0; k < 5; k++) cyc(1, 0, 0);
    #1;
    check("R4 overrun set", 128'(overrun), 128'(1));
    pop_expect(1, "R4 first");
    pop_expect(2, "R4 second");
    pop_expect(3, "R4 third kept");
    cyc(0, 0, 1);

    // R6: release on empty is ignored
    cyc(0, 1, 0);
    #1;
    check("R6 level after empty release", 128'(fill_level), 128'(0));
    check("R6 valid after empty release", 128'(out_valid), 128'(0));
    seq = 10;
    cyc(1, 1, 0);
    #1;
    check("R6 push with empty release", 128'(fill_level), 128'(1));
    drain();

    // R8: push and release together on a full queue
    lock_mode = 1'b0;
    seq = 0;
    for (int k = 0; k < 3; k++) cyc(1, 0, 0);
    cyc(1, 1, 0);
    #1;
    check("R8 level stays 3", 128'(fill_level), 128'(3));
    check("R8 no overrun", 128'(overrun), 128'(0));
    pop_expect(2, "R8 order a");
    pop_expect(3, "R8 order b");
    pop_expect(4, "R8 appended");

    // R5: set and clear in the same cycle, set wins
    for (int k = 0; k < 3; k++) cyc(1, 0, 0);
    cyc(1, 0, 1);
    #1;
    check("R5 set beats clear", 128'(overrun), 128'(1));
    cyc(0, 0, 1);
    drain();

    // Mixed random traffic against the scoreboard
    for (int k = 0; k < 400; k++) begin
      lock_mode = (k >= 200);
      cyc(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 8) == 0);
    end
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule